// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Timing Sequencer

This block produces the serial clock and the active-low chip select for one SPI master, leaving data shifting to a neighbouring shift register. A transfer controller hands it a start pulse and a bit count. The sequencer then drops chip select and waits a setup interval. It clocks out the requested number of bits, waits a hold interval and releases chip select. It then enforces a minimum deselect gap before it accepts the next frame. Each of the five intervals is an independent 8-bit count held as cycles minus one, so any frame shape from one-cycle phases up to long, asymmetric ones is available without a fixed divider.

Along the way it emits one-cycle sample and shift strobes, aligned to the clock edges that the polarity and phase controls select, and a one-cycle done pulse when it is ready again. A keep-select input lets several frames share one chip-select assertion. A synchronous soft reset abandons any frame and returns the outputs to their idle levels.

Top module: `sclk_cs_sequencer`

## Requirements
- R1: After reset, cs_n_o is 1, sclk_o equals cpol_i, and sample_o, shift_o and done_o are 0.
- R2: A start seen in a cycle where the sequencer is idle with chip select released drives cs_n_o low in the next cycle. Chip select stays low for setup+1 cycles before the first bit begins. The setup field is tcfg_i[31:24].
- R3: Each bit first holds sclk_o at the idle level (cpol_i) and then at the opposite level. A high level lasts high+1 cycles, with high in tcfg_i[7:0]. A low level lasts low+1 cycles, with low in tcfg_i[15:8].
- R4: A frame carries nbits_m1_i+1 bits, giving exactly two sclk_o transitions per bit. sclk_o is back at the cpol_i level after the last bit.
- R5: Without keep-select, cs_n_o rises hold+1 cycles after the last clock transition, with hold in tcfg_i[23:16].
- R6: After cs_n_o rises, the sequencer stays busy for idle_gap_i+1 cycles. A start that arrives during this gap is kept and begins its frame as soon as the gap ends, with chip select falling one cycle after the done pulse.
- R7: With cpha_i=0, sample_o pulses in the cycle sclk_o leaves its idle level and shift_o pulses in the cycle it returns. With cpha_i=1 the two roles swap. Neither pulses in any other cycle.
- R8: done_o is high for exactly one cycle, the first cycle the sequencer is idle again. With keep-select, that cycle is the one carrying the last clock transition.
- R9: With keep_cs_i=1 at start, hold, release and gap are skipped and cs_n_o stays low. A following start then begins its first bit in the next cycle, with no setup wait.
- R10: A soft_rst_i pulse returns the sequencer to idle in the next cycle. cs_n_o goes to 1 (also releasing a kept select) and sclk_o goes to cpol_i. No strobe and no done pulse are produced.
- R11: A start that arrives during setup, bit clocking or hold has no effect: no second frame follows.
- R12: An interval field value of 0 gives a one-cycle interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous return to idle |
| tcfg_i | input | 4*IV_W | Packed high, low, hold and setup counts, each cycles minus one |
| idle_gap_i | input | IV_W | Minimum deselect gap, cycles minus one |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | 0: sample on first edge of a bit, 1: sample on second edge |
| start_i | input | 1 | Frame request pulse |
| nbits_m1_i | input | BC_W | Number of bits in the frame minus one |
| keep_cs_i | input | 1 | Keep chip select asserted after this frame |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Active-low chip select |
| sample_o | output | 1 | One-cycle strobe at the sampling edge |
| shift_o | output | 1 | One-cycle strobe at the shifting edge |
| done_o | output | 1 | One-cycle pulse when the sequencer is ready again |

## Verification
A corrupted interval or bit counter shows at the ports within the frame in progress. It appears as a setup, phase, hold or gap length that differs from its field plus one, or as an edge count other than twice the bit count. It is caught at the next clock or chip-select transition. A wrong state, such as a lost pending request or a kept select that is not cleared, shows one cycle after the following done pulse or soft reset through the level of cs_n_o. A strobe mapped to the wrong phase shows in the first edge cycle of any frame.

// File: rtl/sclk_seq_pkg.sv
package sclk_seq_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE  = 3'd0,
      SQ_SETUP = 3'd1,
      SQ_LEAD  = 3'd2,
      SQ_TRAIL = 3'd3,
      SQ_HOLD  = 3'd4,
      SQ_GAP   = 3'd5
   } sq_state_e;

   // field slots inside the packed timing word
   localparam int unsigned FLD_HIGH  = 0;
   localparam int unsigned FLD_LOW   = 1;
   localparam int unsigned FLD_HOLD  = 2;
   localparam int unsigned FLD_SETUP = 3;
   localparam int unsigned FLD_NUM   = 4;

endpackage

// File: rtl/seq_down_cnt.sv
module seq_down_cnt #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (dec && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/seq_len_sel.sv
module seq_len_sel
   import sclk_seq_pkg::*;
#(
   parameter int unsigned IV_W = 8
) (
   input  sq_state_e               tgt,
   input  logic [FLD_NUM*IV_W-1:0] tcfg,
   input  logic [IV_W-1:0]         gap,
   input  logic                    cpol,
   output logic [IV_W-1:0]         len_m1
);

   logic [IV_W-1:0] fld [FLD_NUM];

   for (genvar f = 0; f < FLD_NUM; f++) begin : g_unpack
      assign fld[f] = tcfg[f*IV_W +: IV_W];
   end

   always_comb begin
      unique case (tgt)
         SQ_SETUP: len_m1 = fld[FLD_SETUP];
         SQ_LEAD:  len_m1 = cpol ? fld[FLD_HIGH] : fld[FLD_LOW];
         SQ_TRAIL: len_m1 = cpol ? fld[FLD_LOW]  : fld[FLD_HIGH];
         SQ_HOLD:  len_m1 = fld[FLD_HOLD];
         SQ_GAP:   len_m1 = gap;
         default:  len_m1 = '0;
      endcase
   end

endmodule

// File: rtl/sclk_cs_sequencer.sv
module sclk_cs_sequencer
   import sclk_seq_pkg::*;
#(
   parameter int unsigned IV_W = 8,
   parameter int unsigned BC_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    soft_rst_i,
   input  logic [FLD_NUM*IV_W-1:0] tcfg_i,
   input  logic [IV_W-1:0]         idle_gap_i,
   input  logic                    cpol_i,
   input  logic                    cpha_i,
   input  logic                    start_i,
   input  logic [BC_W-1:0]         nbits_m1_i,
   input  logic                    keep_cs_i,
   output logic                    sclk_o,
   output logic                    cs_n_o,
   output logic                    sample_o,
   output logic                    shift_o,
   output logic                    done_o
);

   initial begin
      assert (IV_W >= 1 && IV_W <= 16) else $error("IV_W out of range");
      assert (BC_W >= 1 && BC_W <= 16) else $error("BC_W out of range");
   end

   sq_state_e       state_q, state_d;
   logic [IV_W-1:0] next_len;
   logic            iv_zero, bc_zero;
   logic            pend_q, keep_q, cs_kept_q;
   logic            edge1_q, edge2_q, done_q;
   logic            go, capture, cs_active;

   // a frame begins from idle on a fresh or a parked request
   assign go      = (state_q == SQ_IDLE) && (start_i || pend_q);
   // requests are taken in idle, or parked while the gap runs
   assign capture = (start_i && (state_q == SQ_GAP)) ||
                    (start_i && (state_q == SQ_IDLE) && !pend_q);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SQ_IDLE:  if (go)      state_d = cs_kept_q ? SQ_LEAD : SQ_SETUP;
         SQ_SETUP: if (iv_zero) state_d = SQ_LEAD;
         SQ_LEAD:  if (iv_zero) state_d = SQ_TRAIL;
         SQ_TRAIL: if (iv_zero) state_d = !bc_zero ? SQ_LEAD :
                                          (keep_q ? SQ_IDLE : SQ_HOLD);
         SQ_HOLD:  if (iv_zero) state_d = SQ_GAP;
         SQ_GAP:   if (iv_zero) state_d = SQ_IDLE;
         default:               state_d = SQ_IDLE;
      endcase
   end

   seq_len_sel #(.IV_W(IV_W)) i_len (
      .tgt    (state_d),
      .tcfg   (tcfg_i),
      .gap    (idle_gap_i),
      .cpol   (cpol_i),
      .len_m1 (next_len)
   );

   // interval timer: reloaded on every state change
   seq_down_cnt #(.W(IV_W)) i_iv_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (soft_rst_i),
      .load     (state_d != state_q),
      .load_val (next_len),
      .dec      (1'b1),
      .zero     (iv_zero)
   );

   // bits still to go after the current one
   seq_down_cnt #(.W(BC_W)) i_bit_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (soft_rst_i),
      .load     (capture),
      .load_val (nbits_m1_i),
      .dec      ((state_q == SQ_TRAIL) && iv_zero && !bc_zero),
      .zero     (bc_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SQ_IDLE;
         pend_q    <= 1'b0;
         keep_q    <= 1'b0;
         cs_kept_q <= 1'b0;
         edge1_q   <= 1'b0;
         edge2_q   <= 1'b0;
         done_q    <= 1'b0;
      end else if (soft_rst_i) begin
         state_q   <= SQ_IDLE;
         pend_q    <= 1'b0;
         keep_q    <= 1'b0;
         cs_kept_q <= 1'b0;
         edge1_q   <= 1'b0;
         edge2_q   <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         edge1_q <= (state_q == SQ_LEAD)  && iv_zero;
         edge2_q <= (state_q == SQ_TRAIL) && iv_zero;
         done_q  <= (state_q != SQ_IDLE) && (state_d == SQ_IDLE);
         if (go) begin
            pend_q <= 1'b0;
         end else if (start_i && (state_q == SQ_GAP)) begin
            pend_q <= 1'b1;
         end
         if (capture) begin
            keep_q <= keep_cs_i;
         end
         if (go) begin
            cs_kept_q <= 1'b0;
         end else if ((state_q == SQ_TRAIL) && (state_d == SQ_IDLE)) begin
            cs_kept_q <= 1'b1;
         end
      end
   end

   assign cs_active = (state_q == SQ_SETUP) || (state_q == SQ_LEAD) ||
                      (state_q == SQ_TRAIL) || (state_q == SQ_HOLD) ||
                      ((state_q == SQ_IDLE) && cs_kept_q);

   assign cs_n_o   = !cs_active;
   assign sclk_o   = cpol_i ^ (state_q == SQ_TRAIL);
   assign sample_o = cpha_i ? edge2_q : edge1_q;
   assign shift_o  = cpha_i ? edge1_q : edge2_q;
   assign done_o   = done_q;

endmodule

// File: rtl/sclk_cs_sequencer_chk.sv
module sclk_cs_sequencer_chk (
   input logic clk,
   input logic rst_n,
   input logic soft_rst_i,
   input logic cpol_i,
   input logic sclk_o,
   input logic cs_n_o,
   input logic sample_o,
   input logic shift_o,
   input logic done_o
);

   a_r2_select_before_clock: assert property (@(posedge clk) disable iff (!rst_n)
      ((sclk_o != $past(sclk_o)) && $stable(cpol_i) && !$past(soft_rst_i))
         |-> (!cs_n_o && !$past(cs_n_o)));

   a_r5_release_at_idle_clock: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |-> (sclk_o == cpol_i));

   a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_o && shift_o));

   a_r7_strobe_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_o || shift_o) |-> (sclk_o != $past(sclk_o)));

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r10_soft_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_i |=> (cs_n_o && !done_o && !sample_o && !shift_o));

endmodule

bind sclk_cs_sequencer sclk_cs_sequencer_chk i_sclk_cs_sequencer_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .soft_rst_i (soft_rst_i),
   .cpol_i     (cpol_i),
   .sclk_o     (sclk_o),
   .cs_n_o     (cs_n_o),
   .sample_o   (sample_o),
   .shift_o    (shift_o),
   .done_o     (done_o)
);

// File: tb/test_sclk_cs_sequencer.sv
module test_sclk_cs_sequencer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst_i = 1'b0;
   logic [31:0] tcfg_i = '0;
   logic [7:0]  idle_gap_i = '0;
   logic        cpol_i = 1'b0;
   logic        cpha_i = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  nbits_m1_i = '0;
   logic        keep_cs_i = 1'b0;
   logic        sclk_o, cs_n_o, sample_o, shift_o, done_o;

   int n_chk = 0;
   int n_err = 0;

   always #5ns clk = ~clk;

   sclk_cs_sequencer i_sclk_cs_sequencer (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst_i (soft_rst_i),
      .tcfg_i     (tcfg_i),
      .idle_gap_i (idle_gap_i),
      .cpol_i     (cpol_i),
      .cpha_i     (cpha_i),
      .start_i    (start_i),
      .nbits_m1_i (nbits_m1_i),
      .keep_cs_i  (keep_cs_i),
      .sclk_o     (sclk_o),
      .cs_n_o     (cs_n_o),
      .sample_o   (sample_o),
      .shift_o    (shift_o),
      .done_o     (done_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int lvl_len(input bit level, input logic [7:0] hi,
                                  input logic [7:0] lo);
      return level ? int'(hi) + 1 : int'(lo) + 1;
   endfunction

   // Runs one frame from a negedge and checks its shape. Returns at the
   // negedge where done_o is seen.
   task automatic run_frame(input logic [7:0] hi, input logic [7:0] lo,
                            input logic [7:0] ho, input logic [7:0] su,
                            input logic [7:0] gp, input bit pol, input bit pha,
                            input int nb, input bit keep, input bit cs_low,
                            input bit no_drive, input bit busy_start,
                            input int gap_start);
      int a_len, b_len, k, t_fall, t_rise, t_done, ne, bad_stb, bad_iv;
      int edges [64];
      bit ps, pc, cs_hi_early, exp_s, exp_h;
      a_len = lvl_len(pol, hi, lo);
      b_len = lvl_len(!pol, hi, lo);
      tcfg_i     = {su, ho, lo, hi};
      idle_gap_i = gp;
      cpol_i     = pol;
      cpha_i     = pha;
      nbits_m1_i = 8'(nb - 1);
      keep_cs_i  = keep;
      start_i    = !no_drive;
      ps = pol; pc = !cs_low;
      k = 0; t_fall = -1; t_rise = -1; t_done = -1; ne = 0;
      bad_stb = 0; bad_iv = 0; cs_hi_early = 1'b0;
      while (t_done < 0 && k < 20000) begin
         @(negedge clk);
         k++;
         if (pc && !cs_n_o && t_fall < 0) t_fall = k;
         if (!pc && cs_n_o) t_rise = k;
         if (cs_low && ne == 0 && cs_n_o) cs_hi_early = 1'b1;
         if (sclk_o != ps) begin
            if (ne < 64) edges[ne] = k;
            ne++;
            exp_s = (sclk_o != pol) ^ pha;
            exp_h = !exp_s;
         end else begin
            exp_s = 1'b0;
            exp_h = 1'b0;
         end
         if (sample_o != exp_s || shift_o != exp_h) bad_stb++;
         if (done_o) t_done = k;
         ps = sclk_o;
         pc = cs_n_o;
         start_i = (busy_start && k == 2) ||
                   (gap_start >= 0 && t_rise >= 0 && k == t_rise + gap_start);
      end
      start_i = 1'b0;
      chk(t_done > 0, "R8", "done pulse seen", t_done, 1);
      if (!cs_low) begin
         chk(t_fall == 1, "R2", "select falls after start", t_fall, 1);
         chk(ne > 0 && edges[0] - t_fall == int'(su) + 1 + a_len, "R2",
             "setup plus first idle-level phase", ne > 0 ? edges[0] - t_fall : -1,
             int'(su) + 1 + a_len);
      end else begin
         chk(!cs_hi_early, "R9", "select held low into next frame", cs_hi_early, 0);
         chk(ne > 0 && edges[0] == 1 + a_len, "R9", "first edge without setup",
             ne > 0 ? edges[0] : -1, 1 + a_len);
      end
      chk(ne == 2 * nb, "R4", "clock transitions", ne, 2 * nb);
      for (int i = 1; i < ne && i < 64; i++) begin
         if (edges[i] - edges[i-1] != ((i % 2 == 1) ? b_len : a_len)) bad_iv++;
      end
      chk(bad_iv == 0, "R3", "high/low phase lengths wrong", bad_iv, 0);
      chk(bad_stb == 0, "R7", "strobe cycles wrong", bad_stb, 0);
      if (ne > 0 && ne <= 64) begin
         if (!keep) begin
            chk(t_rise - edges[ne-1] == int'(ho) + 1, "R5", "hold length",
                t_rise - edges[ne-1], int'(ho) + 1);
            chk(t_done - t_rise == int'(gp) + 1, "R6", "gap length",
                t_done - t_rise, int'(gp) + 1);
         end else begin
            chk(t_rise < 0 && !cs_n_o, "R9", "select kept low", cs_n_o, 0);
            chk(t_done == edges[ne-1], "R8", "done with last edge",
                t_done, edges[ne-1]);
         end
      end
   endtask

   initial begin
      #2000000ns;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      bit prev_keep, pol;
      void'($urandom(32'd20931));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n_o == 1'b1, "R1", "cs_n after reset", cs_n_o, 1);
      chk(sclk_o == 1'b0 && !sample_o && !shift_o && !done_o, "R1",
          "idle outputs after reset", {sclk_o, sample_o, shift_o, done_o}, 0);

      // R12: all intervals at one cycle, both polarities
      run_frame(8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 1'b0, 1'b0, 1, 1'b0, 1'b0, 1'b0, 1'b0, -1);
      run_frame(8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 1'b1, 1'b1, 3, 1'b0, 1'b0, 1'b0, 1'b0, -1);
      // asymmetric phases, long setup
      run_frame(8'd2, 8'd5, 8'd3, 8'd255, 8'd4, 1'b0, 1'b1, 4, 1'b0, 1'b0, 1'b0, 1'b0, -1);
      run_frame(8'd6, 8'd1, 8'd9, 8'd2, 8'd0, 1'b1, 1'b0, 5, 1'b0, 1'b0, 1'b0, 1'b0, -1);
      @(negedge clk);
      chk(done_o == 1'b0, "R8", "done lasts one cycle", done_o, 0);

      // R6: request during gap is kept and served right after done
      run_frame(8'd1, 8'd1, 8'd1, 8'd1, 8'd12, 1'b0, 1'b0, 2, 1'b0, 1'b0, 1'b0, 1'b0, 3);
      run_frame(8'd1, 8'd1, 8'd1, 8'd1, 8'd12, 1'b0, 1'b0, 2, 1'b0, 1'b0, 1'b1, 1'b0, -1);

      // R11: request during a busy frame is dropped
      run_frame(8'd1, 8'd2, 8'd1, 8'd3, 8'd2, 1'b1, 1'b1, 3, 1'b0, 1'b0, 1'b0, 1'b1, -1);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(cs_n_o == 1'b1, "R11", "no extra frame after busy start", cs_n_o, 1);
      end

      // R9: keep-select chained frames
      run_frame(8'd1, 8'd0, 8'd7, 8'd3, 8'd5, 1'b0, 1'b1, 2, 1'b1, 1'b0, 1'b0, 1'b0, -1);
      run_frame(8'd0, 8'd2, 8'd1, 8'd3, 8'd1, 1'b0, 1'b0, 3, 1'b0, 1'b1, 1'b0, 1'b0, -1);

      // constrained random frames
      prev_keep = 1'b0;
      pol = 1'b0;
      for (int i = 0; i < 14; i++) begin
         logic [7:0] h, l, ho, su, gp;
         bit pha, kp;
         int nb;
         h  = 8'($urandom_range(0, 7));
         l  = 8'($urandom_range(0, 7));
         ho = 8'($urandom_range(0, 20));
         su = 8'($urandom_range(0, 20));
         gp = 8'($urandom_range(0, 20));
         if (!prev_keep) pol = 1'($urandom_range(0, 1));
         pha = 1'($urandom_range(0, 1));
         nb  = $urandom_range(1, 24);
         kp  = ($urandom_range(0, 3) == 0);
         run_frame(h, l, ho, su, gp, pol, pha, nb, kp, prev_keep, 1'b0, 1'b0, -1);
         prev_keep = kp;
      end
      if (prev_keep) begin
         run_frame(8'd1, 8'd1, 8'd1, 8'd1, 8'd1, pol, 1'b0, 2, 1'b0, 1'b1, 1'b0, 1'b0, -1);
      end

      // R10: soft reset in the middle of a frame
      tcfg_i = {8'd2, 8'd2, 8'd3, 8'd3};
      cpol_i = 1'b1;
      nbits_m1_i = 8'd7;
      keep_cs_i = 1'b0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (6) @(negedge clk);
      soft_rst_i = 1'b1;
      @(negedge clk);
      soft_rst_i = 1'b0;
      chk(cs_n_o == 1'b1 && sclk_o == 1'b1, "R10", "idle levels after soft reset",
          {cs_n_o, sclk_o}, 3);
      chk(!done_o && !sample_o && !shift_o, "R10", "no pulses after soft reset",
          {done_o, sample_o, shift_o}, 0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(cs_n_o == 1'b1 && !sample_o && !shift_o && !done_o, "R10",
             "stays idle after soft reset", {cs_n_o, sample_o, shift_o, done_o}, 8);
      end

      // R10: soft reset releases a kept select
      run_frame(8'd0, 8'd1, 8'd2, 8'd1, 8'd2, 1'b0, 1'b0, 2, 1'b1, 1'b0, 1'b0, 1'b0, -1);
      soft_rst_i = 1'b1;
      @(negedge clk);
      soft_rst_i = 1'b0;
      chk(cs_n_o == 1'b1, "R10", "kept select released", cs_n_o, 1);
      run_frame(8'd1, 8'd1, 8'd2, 8'd4, 8'd1, 1'b0, 1'b1, 3, 1'b0, 1'b0, 1'b0, 1'b0, -1);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule